// File: doc/BRIEF.md
# Event Acceptance and Masking Unit

This unit sits beside the processor core's status register. Each cycle it looks at nine pending event classes: one non-maskable interrupt, three critical exceptions, one class for ordinary exceptions and four interrupt levels. It weighs them against the current mask bits and picks the most urgent one that may be taken. Taking an event is one atomic step. On a single clock edge the unit raises a one-cycle accept pulse for the context-save logic, reports which class won, and computes the handler address. On that same edge it also produces the status the core must load next: a new mask vector, in which every class at or below the winner's rank is masked, and a new mode value.

The handler address is the event base register combined with a handler offset by bitwise OR. The two are never added, so software must align the base so that its low bits are clear. The four interrupt levels each bring their own 14-bit offset from the interrupt controller. The five exception-type classes use fixed offsets.

Top module: `evt_accept`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `accept`, `evt_id`, `mask_out`, `mode_out` and `target` are all zero.
- R2: The handler address is `evba | offset`, the offset zero-extended to the address width. It is never the sum of the two. Exception-type classes use fixed offsets of 4·(class index + 1): 0x04, 0x08, 0x0C, 0x10 and 0x14 for classes 0 to 4.
- R3: Request bit `evt_req[i]` is class i. Class 0 is the non-maskable interrupt. Classes 1 to 3 are the unrecoverable exception, the TLB multiple hit and the bus error. Class 4 covers ordinary exceptions. Classes 5, 6, 7 and 8 are interrupt levels 3, 2, 1 and 0. Interrupt level k takes its offset from `irq_off[14k+13:14k]`.
- R4: Mask bit positions are: bits 0 to 3 mask interrupt levels 0 to 3, bit 4 masks exceptions (EM), and bit 5 is the global mask (GM). Interrupt level k is not taken while GM or its own level bit is set.
- R5: Class 4 is not taken while EM is set.
- R6: Classes 0 to 3 are taken whatever the mask bits hold.
- R7: Among the classes that may be taken, the one with the lowest index wins. `evt_id` reports that index.
- R8: When interrupt level k is taken, `mask_out` equals the incoming mask with the level bits 0 to k also set. Every other bit is passed through unchanged.
- R9: When any of classes 0 to 4 is taken, all six mask bits are set in `mask_out`, including EM and GM.
- R10: On acceptance `mode_out` becomes 7 for class 0, 6 for classes 1 to 4, and 2+k for interrupt level k. Without acceptance, `mask_out` and `mode_out` follow the previous cycle's `mask_in` and `mode_in`.
- R11: `accept` is high for exactly the cycles that follow an edge at which some class could be taken. `evt_id` and `target` change on that same edge and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_req | input | 9 | Pending event classes, bit i is class i |
| mask_in | input | 6 | Current status mask bits |
| mode_in | input | 3 | Current execution mode |
| evba | input | AW | Event vector base |
| irq_off | input | 4·OW | Autovector offsets of interrupt levels 0 to 3 |
| accept | output | 1 | One-cycle pulse per accepted event |
| evt_id | output | 4 | Index of the accepted class |
| mask_out | output | 6 | Mask vector for the core to load next |
| mode_out | output | 3 | Mode for the core to load next |
| target | output | AW | Handler address |

## Verification
Priority selection and masking decide the same cycle together. A masked source that ranks high must hand the win to an unmasked source that ranks lower. The bench sets this up on purpose in two ways. It holds an interrupt level's own mask bit while a lower level is pending. It also holds EM while an interrupt is pending. It then judges the winner's identity, its offset and the resulting mask vector against a behavioural model. Long random runs, in which masks and requests change every cycle, produce further collisions of this kind. They also cover critical events that arrive while every mask bit is set.

// File: rtl/evt_accept.sv
module evt_accept #(
  parameter int AW = 32,
  parameter int OW = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [8:0]      evt_req,
  input  logic [5:0]      mask_in,
  input  logic [2:0]      mode_in,
  input  logic [AW-1:0]   evba,
  input  logic [4*OW-1:0] irq_off,
  output logic            accept,
  output logic [3:0]      evt_id,
  output logic [5:0]      mask_out,
  output logic [2:0]      mode_out,
  output logic [AW-1:0]   target
);
  localparam int NCLS  = 9;
  localparam int NCRIT = 4;
  localparam int EXC   = 4;
  localparam int EM_B  = 4;
  localparam int GM_B  = 5;

  logic [NCLS-1:0] elig;
  logic [3:0]      win;
  logic            any;
  logic [OW-1:0]   off;
  logic [5:0]      nmask;
  logic [2:0]      nmode;
  int              lvl;

  for (genvar g = 0; g < NCLS; g++) begin : g_el
    if (g < NCRIT) begin : g_crit
      assign elig[g] = evt_req[g];
    end else if (g == EXC) begin : g_exc
      assign elig[g] = evt_req[g] & ~mask_in[EM_B];
    end else begin : g_int
      assign elig[g] = evt_req[g] & ~mask_in[GM_B] & ~mask_in[NCLS-1-g];
    end
  end

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = NCLS-1; i >= 0; i--)
      if (elig[i]) begin
        win = 4'(i);
        any = 1'b1;
      end
  end

  assign lvl = NCLS - 1 - int'(win);

  always_comb begin
    if (win <= 4'(EXC)) begin
      off   = OW'((int'(win) + 1) << 2);
      nmask = 6'h3F;
      nmode = (win == 4'd0) ? 3'd7 : 3'd6;
    end else begin
      off   = irq_off[lvl*OW +: OW];
      nmask = mask_in | {2'b00, 4'((5'd1 << (lvl + 1)) - 5'd1)};
      nmode = 3'(2 + lvl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept   <= 1'b0;
      evt_id   <= '0;
      mask_out <= '0;
      mode_out <= '0;
      target   <= '0;
    end else begin
      accept <= any;
      if (any) begin
        evt_id   <= win;
        mask_out <= nmask;
        mode_out <= nmode;
        target   <= evba | {{(AW-OW){1'b0}}, off};
      end else begin
        mask_out <= mask_in;
        mode_out <= mode_in;
      end
    end
  end

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> ($stable(target) && $stable(evt_id)));

  // R6
  crit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_req[3:0]) |=> (accept && evt_id < 4'd4));

  // R4
  gm_blocks_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_in[GM_B] && evt_req[3:0] == 4'b0 && !evt_req[4]) |=> !accept);

  // R9
  exc_sets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && evt_id <= 4'd4) |-> (mask_out == 6'h3F));

  // R10
  nmi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && evt_id == 4'd0) |-> (mode_out == 3'd7));
endmodule

// File: tb/evt_accept_test.sv
module evt_accept_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  evt_req = '0;
  logic [5:0]  mask_in = '0;
  logic [2:0]  mode_in = '0;
  logic [31:0] evba = '0;
  logic [55:0] irq_off = '0;
  logic        accept;
  logic [3:0]  evt_id;
  logic [5:0]  mask_out;
  logic [2:0]  mode_out;
  logic [31:0] target;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic        e_acc;
  logic [3:0]  e_id;
  logic [5:0]  e_mask;
  logic [2:0]  e_mode;
  logic [31:0] e_tgt;

  always #2 clk = ~clk;

  evt_accept uut (.clk(clk), .rst_n(rst_n), .evt_req(evt_req), .mask_in(mask_in),
    .mode_in(mode_in), .evba(evba), .irq_off(irq_off), .accept(accept),
    .evt_id(evt_id), .mask_out(mask_out), .mode_out(mode_out), .target(target));

  always @(posedge clk) begin
    if (!rst_n) begin
      e_acc = 0; e_id = 0; e_mask = 0; e_mode = 0; e_tgt = 0;
    end else begin
      integer w;
      w = -1;
      for (int i = 0; i < 9; i++) begin
        bit ok;
        if (i < 4) ok = 1;
        else if (i == 4) ok = !mask_in[4];
        else ok = !mask_in[5] && !mask_in[8-i];
        if (w < 0 && evt_req[i] && ok) w = i;
      end
      e_acc = (w >= 0);
      if (w < 0) begin
        e_mask = mask_in;
        e_mode = mode_in;
      end else begin
        e_id = w[3:0];
        if (w <= 4) begin
          e_mask = 6'h3F;
          e_mode = (w == 0) ? 3'd7 : 3'd6;
          e_tgt = evba | ((w + 1) * 4);
        end else begin
          integer k;
          k = 8 - w;
          e_mask = mask_in;
          for (int j = 0; j <= k; j++) e_mask[j] = 1'b1;
          e_mode = 3'(2 + k);
          e_tgt = evba | {18'b0, irq_off[k*14 +: 14]};
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("accept", 32'(accept), 32'(e_acc));
    chk("evt_id", 32'(evt_id), 32'(e_id));
    chk("mask_out", 32'(mask_out), 32'(e_mask));
    chk("mode_out", 32'(mode_out), 32'(e_mode));
    chk("target", target, e_tgt);
  endtask

  task automatic step(input logic [8:0] r, input logic [5:0] m, input logic [2:0] md,
                      input logic [31:0] b, input string t);
    @(negedge clk);
    compare();
    cur_tag = t;
    evt_req = r; mask_in = m; mode_in = md; evba = b;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    irq_off = {14'h0340, 14'h0230, 14'h0120, 14'h0104};
    evt_req = 9'h1FF; mask_in = 6'h00;
    repeat (3) @(negedge clk);
    // R1: outputs stay zero under reset even with requests pending
    chk("accept", 32'(accept), 0);
    chk("target", target, 0);
    chk("mask_out", 32'(mask_out), 0);
    evt_req = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    // R2: OR versus add distinguishes 0x0F04 from 0x1004
    step(9'h100, 6'h00, 3'd1, 32'h0000_0F00, "R2");
    step(9'h010, 6'h00, 3'd1, 32'h8000_0000, "R2");
    // R3: each interrupt level alone, distinct offsets
    step(9'h100, 6'h00, 3'd1, 32'h0001_0000, "R3");
    step(9'h080, 6'h00, 3'd1, 32'h0001_0000, "R3");
    step(9'h040, 6'h00, 3'd1, 32'h0001_0000, "R3");
    step(9'h020, 6'h00, 3'd1, 32'h0001_0000, "R3");
    // R4: GM blocks, own level bit blocks, lower unmasked level wins
    step(9'h040, 6'h20, 3'd1, 32'h0002_0000, "R4");
    step(9'h040, 6'h04, 3'd1, 32'h0002_0000, "R4");
    step(9'h140, 6'h04, 3'd1, 32'h0002_0000, "R4");
    // R5: EM blocks exceptions, interrupt level 3 wins
    step(9'h010, 6'h10, 3'd2, 32'h0002_0000, "R5");
    step(9'h030, 6'h10, 3'd2, 32'h0002_0000, "R5");
    // R6: critical classes with every mask bit set
    step(9'h001, 6'h3F, 3'd3, 32'h0003_0000, "R6");
    step(9'h002, 6'h3F, 3'd3, 32'h0003_0000, "R6");
    step(9'h004, 6'h3F, 3'd3, 32'h0003_0000, "R6");
    step(9'h008, 6'h3F, 3'd3, 32'h0003_0000, "R6");
    // R7: priority among all pending
    step(9'h1FF, 6'h00, 3'd0, 32'h0004_0000, "R7");
    step(9'h1F0, 6'h00, 3'd0, 32'h0004_0000, "R7");
    step(9'h1C0, 6'h00, 3'd0, 32'h0004_0000, "R7");
    // R8: level 1 taken with I3M set: bits 0,1 added, bit 3 kept
    step(9'h080, 6'h08, 3'd0, 32'h0005_0000, "R8");
    // R9: exception from a clear mask
    step(9'h010, 6'h00, 3'd0, 32'h0005_0000, "R9");
    // R10: no request, mode and mask follow inputs
    step(9'h000, 6'h15, 3'd5, 32'h0005_0000, "R10");
    // R11: accept then idle, target and id held
    step(9'h020, 6'h00, 3'd5, 32'h0006_0000, "R11");
    step(9'h000, 6'h00, 3'd5, 32'h0007_0000, "R11");
    step(9'h000, 6'h00, 3'd5, 32'h0007_0000, "R11");
    for (int n = 0; n < 3000; n++) begin
      irq_off = {$urandom, $urandom};
      step(9'($urandom & ((n % 3 == 0) ? 32'h1F0 : 32'h1FF)), 6'($urandom), 3'($urandom),
           $urandom & 32'hFFFF_C000 | ($urandom & 32'h3), "R7");
    end
    step(9'h000, 6'h00, 3'd0, 32'h0, "R11");
    @(negedge clk);
    compare();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule